// File: doc/BRIEF.md
# Per-Thread Permission Restriction Unit

This block works out the access rights a memory access actually gets. The page table supplies a default read/write/execute set for the page's permission class. Each hardware thread owns a restriction register that holds one remove-mask field per class. The effective rights are the default rights with every bit set in the active thread's field cleared. Software can withdraw write or execute rights from a whole class of regions with one register write. No page table entry is rewritten and no walk is needed.

A lookup is combinational from the request inputs and the stored restriction registers. A register write lands on the clock edge, so an access presented in the cycle after the write already sees the new mask. A fault output flags a requested right that the effective set lacks, and a cause vector names the missing rights. The page walker and the TLB sit outside this block. They feed `req_class` and `req_default` and consume the result.

Top module: `perm_restrict_unit`

## Requirements
- R1: `eff_perm` equals `req_default` with every bit removed that is set in field `req_class` of the restriction register of thread `thread_sel`. Field c occupies bits [3c+2:3c], and the field bits line up with the permission bits: bit 0 read, bit 1 write, bit 2 execute.
- R2: A class whose default is RWX (3'b111), with a field that removes write (3'b010), resolves to read+execute (3'b101).
- R3: A class whose default is RWX, with a field that removes execute (3'b100), resolves to read+write (3'b011).
- R4: Each thread has its own restriction register. Changing `thread_sel` changes the mask applied, so the same class can be executable under one thread and writable under another. A write to one thread leaves every other thread's register unchanged.
- R5: After reset every restriction register is empty, and with an empty field `eff_perm` equals `req_default` exactly.
- R6: When `req_valid` is high, `fault_cause` equals `req_access & ~eff_perm`, and `fault` is high exactly when `fault_cause` is nonzero. `req_access` uses the same bit order as the permissions.
- R7: A write presented with `wr_en` high takes effect for lookups in the following cycle. A lookup in the same cycle as the write still sees the old register value.
- R8: A restriction never adds rights: `eff_perm` is always a subset of `req_default`.
- R9: When `req_valid` is low, `fault` is 0 and `fault_cause` is 0.
- R10: One write replaces all class fields of the addressed thread at once, including clearing fields that were previously set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for a restriction register |
| wr_thread | input | 2 | Thread whose register is written |
| wr_data | input | 24 | New restriction value, 3 bits per class |
| thread_sel | input | 2 | Thread currently running |
| req_valid | input | 1 | An access is being checked |
| req_class | input | 3 | Permission class of the page |
| req_default | input | 3 | Default rights from the page table (bit0 R, bit1 W, bit2 X) |
| req_access | input | 3 | Rights the access needs (same order) |
| eff_perm | output | 3 | Effective rights after restriction |
| fault | output | 1 | Access needs a right it does not have |
| fault_cause | output | 3 | Which requested rights are missing |

## Verification
If a stored register bit is corrupted or written to the wrong thread, the damage stays hidden until a lookup selects that thread and class. At that point it shows at once, in the same cycle, as a wrong `eff_perm` bit and possibly a spurious or missing fault. The bench therefore sweeps all threads and classes after writes, not just the class just written. Its reference model is compared on every cycle. A write that lands one cycle late or early shows up in the cycle right after the write, where the old and new masks differ.

// File: rtl/perm_restrict_pkg.sv
package perm_restrict_pkg;
   localparam int PERM_BITS = 3;
   localparam int BIT_READ  = 0;
   localparam int BIT_WRITE = 1;
   localparam int BIT_EXEC  = 2;
   typedef logic [PERM_BITS-1:0] perm_t;
endpackage

// File: rtl/restrict_bank.sv
module restrict_bank #(
   parameter int NUM_THREADS = 4,
   parameter int REG_W       = 24,
   localparam int THREAD_W   = $clog2(NUM_THREADS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [THREAD_W-1:0] wr_thread,
   input  logic [REG_W-1:0]    wr_data,
   input  logic [THREAD_W-1:0] rd_thread,
   output logic [REG_W-1:0]    rd_data
);
   logic [NUM_THREADS*REG_W-1:0] bank_flat;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic [REG_W-1:0] q;
      logic             hit;
      assign hit = wr_en && (wr_thread == THREAD_W'(t));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (hit) q <= wr_data;
      end
      assign bank_flat[t*REG_W +: REG_W] = q;
   end

   assign rd_data = bank_flat[rd_thread*REG_W +: REG_W];
endmodule

// File: rtl/class_field_sel.sv
module class_field_sel #(
   parameter int NUM_CLASSES = 8,
   parameter int FIELD_W     = 3,
   localparam int CLASS_W    = $clog2(NUM_CLASSES),
   localparam int REG_W      = NUM_CLASSES * FIELD_W
) (
   input  logic [REG_W-1:0]   reg_in,
   input  logic [CLASS_W-1:0] cls,
   output logic [FIELD_W-1:0] field_out
);
   logic [FIELD_W-1:0] fields [NUM_CLASSES];

   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_fld
      assign fields[c] = reg_in[c*FIELD_W +: FIELD_W];
   end

   assign field_out = fields[cls];
endmodule

// File: rtl/perm_combine.sv
module perm_combine
   import perm_restrict_pkg::*;
(
   input  logic  valid,
   input  perm_t dflt,
   input  perm_t remove,
   input  perm_t access,
   output perm_t eff,
   output logic  fault,
   output perm_t cause
);
   perm_t missing;
   assign eff     = dflt & ~remove;
   assign missing = access & ~eff;
   assign cause   = valid ? missing : '0;
   assign fault   = |cause;
endmodule

// File: rtl/perm_restrict_unit.sv
module perm_restrict_unit
   import perm_restrict_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int NUM_CLASSES = 8,
   parameter bit REG_OUT     = 1'b0,
   localparam int THREAD_W   = $clog2(NUM_THREADS),
   localparam int CLASS_W    = $clog2(NUM_CLASSES),
   localparam int REG_W      = NUM_CLASSES * PERM_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [THREAD_W-1:0] wr_thread,
   input  logic [REG_W-1:0]    wr_data,
   input  logic [THREAD_W-1:0] thread_sel,
   input  logic                req_valid,
   input  logic [CLASS_W-1:0]  req_class,
   input  logic [2:0]          req_default,
   input  logic [2:0]          req_access,
   output logic [2:0]          eff_perm,
   output logic                fault,
   output logic [2:0]          fault_cause
);
   if (NUM_THREADS < 2) begin : g_chk_thr
      $error("perm_restrict_unit: NUM_THREADS must be at least 2");
   end
   if (NUM_CLASSES < 2) begin : g_chk_cls
      $error("perm_restrict_unit: NUM_CLASSES must be at least 2");
   end
   if ((1 << THREAD_W) != NUM_THREADS) begin : g_chk_pow
      $error("perm_restrict_unit: NUM_THREADS must be a power of two");
   end

   logic [REG_W-1:0] active_reg;
   perm_t            remove_mask;
   perm_t            eff_c, cause_c;
   logic             fault_c;

   restrict_bank #(.NUM_THREADS(NUM_THREADS), .REG_W(REG_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_thread (wr_thread),
      .wr_data   (wr_data),
      .rd_thread (thread_sel),
      .rd_data   (active_reg)
   );

   class_field_sel #(.NUM_CLASSES(NUM_CLASSES), .FIELD_W(PERM_BITS)) u_sel (
      .reg_in    (active_reg),
      .cls       (req_class),
      .field_out (remove_mask)
   );

   perm_combine u_comb (
      .valid  (req_valid),
      .dflt   (req_default),
      .remove (remove_mask),
      .access (req_access),
      .eff    (eff_c),
      .fault  (fault_c),
      .cause  (cause_c)
   );

   if (REG_OUT) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            eff_perm    <= '0;
            fault       <= 1'b0;
            fault_cause <= '0;
         end else begin
            eff_perm    <= eff_c;
            fault       <= fault_c;
            fault_cause <= cause_c;
         end
      end
   end else begin : g_out_comb
      assign eff_perm    = eff_c;
      assign fault       = fault_c;
      assign fault_cause = cause_c;
   end
endmodule

// File: rtl/perm_restrict_unit_chk.sv
module perm_restrict_unit_chk #(
   parameter int NUM_THREADS = 4,
   parameter int NUM_CLASSES = 8,
   parameter bit REG_OUT     = 1'b0,
   localparam int THREAD_W   = $clog2(NUM_THREADS),
   localparam int CLASS_W    = $clog2(NUM_CLASSES),
   localparam int REG_W      = NUM_CLASSES * 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [THREAD_W-1:0] wr_thread,
   input logic [REG_W-1:0]    wr_data,
   input logic [THREAD_W-1:0] thread_sel,
   input logic                req_valid,
   input logic [CLASS_W-1:0]  req_class,
   input logic [2:0]          req_default,
   input logic [2:0]          req_access,
   input logic [2:0]          eff_perm,
   input logic                fault,
   input logic [2:0]          fault_cause
);
   logic                lw_valid;
   logic [THREAD_W-1:0] lw_thread;
   logic [REG_W-1:0]    lw_data;
   logic                ever_written;
   logic [2:0]          lw_field;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lw_valid     <= 1'b0;
         lw_thread    <= '0;
         lw_data      <= '0;
         ever_written <= 1'b0;
      end else begin
         lw_valid  <= wr_en;
         lw_thread <= wr_thread;
         lw_data   <= wr_data;
         if (wr_en) ever_written <= 1'b1;
      end
   end

   assign lw_field = lw_data[req_class*3 +: 3];

   if (!REG_OUT) begin : g_comb_props
      AST_EFF_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
         (eff_perm & ~req_default) == 3'b000);                               // R8
      AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |-> (!fault && fault_cause == 3'b000));                  // R9
      AST_CAUSE_MISSING: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |-> (fault_cause == (req_access & ~eff_perm)));           // R6
      AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |-> (fault == (fault_cause != 3'b000)));                  // R6
      AST_EMPTY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         !ever_written |-> (eff_perm == req_default));                       // R5
      AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
         (lw_valid && lw_thread == thread_sel && !wr_en)
         |-> (eff_perm == (req_default & ~lw_field)));                       // R7
   end
endmodule

bind perm_restrict_unit perm_restrict_unit_chk #(
   .NUM_THREADS (NUM_THREADS),
   .NUM_CLASSES (NUM_CLASSES),
   .REG_OUT     (REG_OUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_thread   (wr_thread),
   .wr_data     (wr_data),
   .thread_sel  (thread_sel),
   .req_valid   (req_valid),
   .req_class   (req_class),
   .req_default (req_default),
   .req_access  (req_access),
   .eff_perm    (eff_perm),
   .fault       (fault),
   .fault_cause (fault_cause)
);

// File: tb/perm_restrict_unit_test.sv
`timescale 1ns/100ps
module perm_restrict_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_thread = '0;
   logic [23:0] wr_data = '0;
   logic [1:0]  thread_sel = '0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_class = '0;
   logic [2:0]  req_default = '0;
   logic [2:0]  req_access = '0;
   logic [2:0]  eff_perm;
   logic        fault;
   logic [2:0]  fault_cause;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [23:0] model_reg [4];

   always #2.5 clk = ~clk;

   perm_restrict_unit uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_thread(wr_thread),
      .wr_data(wr_data), .thread_sel(thread_sel), .req_valid(req_valid),
      .req_class(req_class), .req_default(req_default), .req_access(req_access),
      .eff_perm(eff_perm), .fault(fault), .fault_cause(fault_cause)
   );

   // behavioural reference: register file per thread, updated on the edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < 4; t++) model_reg[t] <= '0;
      end else if (wr_en) begin
         model_reg[wr_thread] <= wr_data;
      end
   end

   task automatic compare(input string tag);
      logic [2:0] mask, exp_eff, exp_cause;
      logic       exp_fault;
      mask      = (model_reg[thread_sel] >> (int'(req_class) * 3)) & 24'h7;
      exp_eff   = req_default & ~mask;
      exp_cause = req_valid ? (req_access & ~exp_eff) : 3'b000;
      exp_fault = (exp_cause != 3'b000);
      checks++;
      if (eff_perm !== exp_eff || fault !== exp_fault || fault_cause !== exp_cause) begin
         fails++;
         $display("FAIL %s: eff=%b fault=%b cause=%b expected eff=%b fault=%b cause=%b",
                  tag, eff_perm, fault, fault_cause, exp_eff, exp_fault, exp_cause);
      end
   endtask

   task automatic step(input bit we, input logic [1:0] wt, input logic [23:0] wd,
                       input logic [1:0] th, input bit v, input logic [2:0] cls,
                       input logic [2:0] dflt, input logic [2:0] acc, input string tag);
      @(negedge clk);
      wr_en = we; wr_thread = wt; wr_data = wd;
      thread_sel = th; req_valid = v; req_class = cls;
      req_default = dflt; req_access = acc;
      #1 compare(tag);
   endtask

   function automatic logic [23:0] field(input int cls, input logic [2:0] m);
      return 24'(m) << (cls * 3);
   endfunction

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R5 reset: every thread and class passes defaults through
      for (int t = 0; t < 4; t++)
         for (int c = 0; c < 8; c++)
            step(0, 0, 0, 2'(t), 1, 3'(c), 3'b111, 3'b111, "R5 reset pass-through");

      // R2: thread 0, class 3 remove write
      step(1, 0, field(3, 3'b010), 0, 0, 0, 3'b111, 0, "R7 write cycle");
      step(0, 0, 0, 0, 1, 3, 3'b111, 3'b001, "R2 RWX minus W");
      if (eff_perm !== 3'b101) begin
         fails++; $display("FAIL R2: eff=%b expected=101", eff_perm);
      end
      checks++;
      step(0, 0, 0, 0, 1, 3, 3'b111, 3'b010, "R6 write fault");

      // R3: thread 1, class 3 remove execute
      step(1, 1, field(3, 3'b100), 1, 0, 3, 3'b111, 0, "R9 idle during write");
      step(0, 0, 0, 1, 1, 3, 3'b111, 3'b100, "R3 RWX minus X");
      if (eff_perm !== 3'b011 || fault !== 1'b1 || fault_cause !== 3'b100) begin
         fails++; $display("FAIL R3: eff=%b cause=%b expected eff=011 cause=100", eff_perm, fault_cause);
      end
      checks++;

      // R4: same class executable in thread 0, writable in thread 1
      step(0, 0, 0, 0, 1, 3, 3'b111, 3'b100, "R4 thread0 exec allowed");
      step(0, 0, 0, 1, 1, 3, 3'b111, 3'b010, "R4 thread1 write allowed");
      for (int c = 0; c < 8; c++)
         step(0, 0, 0, 2, 1, 3'(c), 3'b111, 3'b111, "R4 untouched thread2");

      // R7: lookup in the write cycle sees old mask, next cycle sees new
      step(1, 2, field(5, 3'b111), 2, 1, 5, 3'b111, 3'b111, "R7 old value in write cycle");
      step(0, 0, 0, 2, 1, 5, 3'b111, 3'b001, "R7 new value next cycle");

      // R10: full overwrite clears previous fields
      step(1, 2, field(1, 3'b001), 2, 0, 0, 0, 0, "R10 overwrite");
      step(0, 0, 0, 2, 1, 5, 3'b111, 3'b111, "R10 old field cleared");
      step(0, 0, 0, 2, 1, 1, 3'b111, 3'b001, "R10 new field active");

      // R8: restrictions never add rights to a sparse default
      step(0, 0, 0, 2, 1, 1, 3'b010, 3'b101, "R8 no added rights");

      // R1 / R6 / R9 random sweep
      for (int i = 0; i < 3000; i++) begin
         step(1'($urandom_range(0, 3) == 0), 2'($urandom), 24'($urandom),
              2'($urandom), 1'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
              "R1 random lookup");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule